// File: doc/BRIEF.md
# Two-Lane Look-Ahead Cascaded IIR Low-Pass Filter

This block smooths a sample stream with a cascade of single-pole low-pass sections, each of the form y(k) = (1-a)·y(k-1) + a·x(k). It accepts two consecutive samples in every clock and returns the two matching filtered samples in every clock. It serves as the loop filter of a digital phase-locked loop whose detector delivers error samples at twice the rate the filter clock could handle serially.

Each section is rewritten one step ahead. An output is formed from the output two samples back, weighted by (1-a)², plus the sample one back, weighted by a(1-a), plus the current sample, weighted by a. The earlier lane and the later lane each feed back only onto themselves, through a single register. The lane pair therefore advances two samples per clock with the same recursive depth as a one-sample serial filter. Every coefficient comes from the smoothing factor at elaboration, with no rounding. The three products of a lane are summed at full precision and rounded once to the state width. The state carries guard bits below the sample LSB. The output stage rounds them away and saturates to the sample width.

Doubling the loop's sample rate doubles the bandwidth of the surrounding loop unless its integral gain is halved. The block therefore drives a constant flag that tells the loop controller to shift its integral constant right by one bit.

Top module: `iir2x_lookahead`

## Requirements
- R1: `in_early` carries sample 2n and `in_late` carries sample 2n+1 of the stream. `out_early` carries filtered sample 2n and `out_late` carries filtered sample 2n+1.
- R2: Every output lane is within one LSB of a serial real-valued cascade of NUM_STAGES sections y = (1-a)·y + a·x. Here a = ALPHA_Q / 2^COEF_FRAC (0.25 by default), the states start at zero after reset, and only accepted samples advance the cascade.
- R3: Inputs anywhere in the full signed range of DATA_W bits cause no wrap-around of the internal state. Full-scale positive and negative steps settle to the input value within one LSB.
- R4: `out_valid` rises exactly NUM_STAGES clocks (one per section) after the clock that accepted `in_valid`. The output pair is the one computed from that input pair.
- R5: While `in_valid` is low, no section state advances. While `out_valid` is low, both output lanes hold their values. Idle gaps between pairs do not change any later output.
- R6: A synchronous active-low reset clears every section state and the held late-lane sample. While reset is applied, the outputs read zero and `out_valid` is low.
- R7: `loop_gain_shift` reads 1. It tells the surrounding loop to shift its integral constant right by one bit to keep the loop bandwidth.
- R8: A sample on the late lane reaches the early-lane output of the next pair through the held sample, with weight a(1-a) in the first section.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | The input pair is valid in this clock |
| in_early | input | DATA_W | Earlier sample of the pair, signed |
| in_late | input | DATA_W | Later sample of the pair, signed |
| out_valid | output | 1 | A new output pair is present |
| out_early | output | DATA_W | Filtered earlier sample, signed |
| out_late | output | DATA_W | Filtered later sample, signed |
| loop_gain_shift | output | 1 | Constant 1: halve the integral gain of the surrounding loop |

## Verification
The state-bound property assumes the inputs are legal signed DATA_W values and that ALPHA_Q lies strictly between 0 and 2^COEF_FRAC. Under those limits each section forms a convex blend and cannot leave the input range by more than rounding. The hold and latency properties assume `in_valid` is a plain per-clock strobe with no handshake. The stimulus therefore drives only in-range samples (impulses, full-scale steps, DC levels swept across the range, alternating signs, a ramp and pseudo-random pairs), inserts idle gaps of random length, and applies reset once at start and once mid-stream while pairs are still in flight.

// File: rtl/iir2x_pkg.sv
// Package: shared coefficient arithmetic for the two-lane look-ahead filter.
// Coefficients are scaled by 2^(2*frac) so that a, a(1-a) and (1-a)^2 are
// all exact integers: no coefficient rounding is introduced.
package iir2x_pkg;

    // Weight of the current sample: a, scaled by 2^(2*frac).
    function automatic longint coef_near(input int aq, input int frac);
        return longint'(aq) << frac;
    endfunction

    // Weight of the sample one step back: a(1-a), scaled by 2^(2*frac).
    function automatic longint coef_far(input int aq, input int frac);
        return longint'(aq) * ((longint'(1) << frac) - longint'(aq));
    endfunction

    // Weight of the lane's own previous output: (1-a)^2, scaled by 2^(2*frac).
    function automatic longint coef_fb(input int aq, input int frac);
        longint b;
        b = (longint'(1) << frac) - longint'(aq);
        return b * b;
    endfunction

endpackage

// File: rtl/iir2x_mac.sv
// Module: one lane of one look-ahead section (combinational).
// Computes y_next = (1-a)^2*y_fb + a(1-a)*x_far + a*x_near at full precision
// and rounds once (half up) to the state width.
// Assumes: coefficients carry FRAC2 fraction bits; the filter is stable, so
// the rounded result always fits in SW bits.
module iir2x_mac #(
    parameter int     SW    = 20,
    parameter int     CW    = 18,
    parameter int     FRAC2 = 16,
    parameter longint K_FB  = 36864,
    parameter longint K_FAR = 12288,
    parameter longint K_NR  = 16384
) (
    input  logic signed [SW-1:0] y_fb,
    input  logic signed [SW-1:0] x_far,
    input  logic signed [SW-1:0] x_near,
    output logic signed [SW-1:0] y_next
);
    localparam int PW = SW + CW + 2;
    localparam logic signed [PW-1:0] C_FB  = PW'(K_FB);
    localparam logic signed [PW-1:0] C_FAR = PW'(K_FAR);
    localparam logic signed [PW-1:0] C_NR  = PW'(K_NR);
    localparam logic signed [PW-1:0] RND   = PW'(longint'(1) << (FRAC2 - 1));

    logic signed [PW-1:0] fb_x;
    logic signed [PW-1:0] far_x;
    logic signed [PW-1:0] near_x;
    logic signed [PW-1:0] acc;

    // Sign-extend the operands, sum the three products, round once.
    always_comb begin
        fb_x   = PW'(y_fb);
        far_x  = PW'(x_far);
        near_x = PW'(x_near);
        acc    = fb_x * C_FB + far_x * C_FAR + near_x * C_NR + RND;
        y_next = SW'(acc >>> FRAC2);
    end

endmodule

// File: rtl/iir2x_stage.sv
// Module: one single-pole section in two-lane look-ahead form.
// Lane 0 produces y(2n)   = b^2*y(2n-2) + ab*x(2n-1) + a*x(2n)
// Lane 1 produces y(2n+1) = b^2*y(2n-1) + ab*x(2n)   + a*x(2n+1)
// where b = 1-a. Each lane feeds back only onto itself through one register.
// x(2n-1) is the late-lane sample of the previous accepted pair, held here.
// Assumes: in_vld is a per-clock strobe; state advances only when it is high.
module iir2x_stage #(
    parameter int     SW    = 20,
    parameter int     CW    = 18,
    parameter int     FRAC2 = 16,
    parameter longint K_FB  = 36864,
    parameter longint K_FAR = 12288,
    parameter longint K_NR  = 16384
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_vld,
    input  logic signed [SW-1:0] x_e,
    input  logic signed [SW-1:0] x_o,
    output logic signed [SW-1:0] y_e,
    output logic signed [SW-1:0] y_o,
    output logic                 out_vld
);
    localparam int LANES = 2;

    logic signed [SW-1:0] y_q    [LANES];
    logic signed [SW-1:0] y_d    [LANES];
    logic signed [SW-1:0] far_w  [LANES];
    logic signed [SW-1:0] near_w [LANES];
    logic signed [SW-1:0] late_held;
    logic                 vld_q;

    // Route the one-back and current samples to each lane.
    assign far_w[0]  = late_held;
    assign near_w[0] = x_e;
    assign far_w[1]  = x_e;
    assign near_w[1] = x_o;

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        iir2x_mac #(
            .SW(SW), .CW(CW), .FRAC2(FRAC2),
            .K_FB(K_FB), .K_FAR(K_FAR), .K_NR(K_NR)
        ) u_mac (
            .y_fb  (y_q[ln]),
            .x_far (far_w[ln]),
            .x_near(near_w[ln]),
            .y_next(y_d[ln])
        );
    end

    // Register lane states, the held late sample and the valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y_q[0]    <= '0;
            y_q[1]    <= '0;
            late_held <= '0;
            vld_q     <= 1'b0;
        end else begin
            vld_q <= in_vld;
            if (in_vld) begin
                y_q[0]    <= y_d[0];
                y_q[1]    <= y_d[1];
                late_held <= x_o;
            end
        end
    end

    assign y_e     = y_q[0];
    assign y_o     = y_q[1];
    assign out_vld = vld_q;

endmodule

// File: rtl/iir2x_outfmt.sv
// Module: converts a state word (GW guard bits) to an output sample.
// Rounds half up, then saturates to the signed DW-bit range.
// Assumes: GW >= 1 and SW > DW + GW.
module iir2x_outfmt #(
    parameter int SW = 20,
    parameter int DW = 12,
    parameter int GW = 6
) (
    input  logic signed [SW-1:0] st,
    output logic signed [DW-1:0] q
);
    localparam int SW1 = SW + 1;
    localparam logic signed [SW:0] HALF = SW1'(longint'(1) << (GW - 1));
    localparam logic signed [SW:0] MAXV = SW1'((longint'(1) << (DW - 1)) - 1);
    localparam logic signed [SW:0] MINV = -MAXV - SW1'(1);

    logic signed [SW:0] sum;
    logic signed [SW:0] shd;

    // Round away the guard bits and clamp to the sample range.
    always_comb begin
        sum = SW1'(st) + HALF;
        shd = sum >>> GW;
        if (shd > MAXV)      q = DW'(MAXV);
        else if (shd < MINV) q = DW'(MINV);
        else                 q = DW'(shd);
    end

endmodule

// File: rtl/iir2x_lookahead.sv
// Module: top of the two-lane look-ahead IIR low-pass cascade.
// Takes two consecutive samples per clock (early = even, late = odd), runs
// NUM_STAGES look-ahead sections in series, and returns both filtered lanes
// NUM_STAGES clocks later with a matching valid strobe.
// Assumes: 0 < ALPHA_Q < 2^COEF_FRAC; inputs are plain signed DATA_W values.
module iir2x_lookahead #(
    parameter int DATA_W     = 12,
    parameter int GUARD_W    = 6,
    parameter int COEF_FRAC  = 8,
    parameter int ALPHA_Q    = 64,
    parameter int NUM_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_early,
    input  logic signed [DATA_W-1:0] in_late,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_early,
    output logic signed [DATA_W-1:0] out_late,
    output logic                     loop_gain_shift
);
    import iir2x_pkg::*;

    localparam int     SW    = DATA_W + GUARD_W + 2;
    localparam int     CW    = 2 * COEF_FRAC + 2;
    localparam int     FRAC2 = 2 * COEF_FRAC;
    localparam longint K_FB  = coef_fb(ALPHA_Q, COEF_FRAC);
    localparam longint K_FAR = coef_far(ALPHA_Q, COEF_FRAC);
    localparam longint K_NR  = coef_near(ALPHA_Q, COEF_FRAC);

    logic signed [SW-1:0] st_e [NUM_STAGES+1];
    logic signed [SW-1:0] st_o [NUM_STAGES+1];
    logic                 st_v [NUM_STAGES+1];

    // Widen the input samples into state format (guard bits appended).
    assign st_e[0] = SW'(in_early) <<< GUARD_W;
    assign st_o[0] = SW'(in_late) <<< GUARD_W;
    assign st_v[0] = in_valid;

    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
        iir2x_stage #(
            .SW(SW), .CW(CW), .FRAC2(FRAC2),
            .K_FB(K_FB), .K_FAR(K_FAR), .K_NR(K_NR)
        ) u_stage (
            .clk    (clk),
            .rst_n  (rst_n),
            .in_vld (st_v[s]),
            .x_e    (st_e[s]),
            .x_o    (st_o[s]),
            .y_e    (st_e[s+1]),
            .y_o    (st_o[s+1]),
            .out_vld(st_v[s+1])
        );
    end

    iir2x_outfmt #(.SW(SW), .DW(DATA_W), .GW(GUARD_W)) u_fmt_early (
        .st(st_e[NUM_STAGES]),
        .q (out_early)
    );

    iir2x_outfmt #(.SW(SW), .DW(DATA_W), .GW(GUARD_W)) u_fmt_late (
        .st(st_o[NUM_STAGES]),
        .q (out_late)
    );

    assign out_valid       = st_v[NUM_STAGES];
    // Two samples per clock doubles the loop rate: halve the integral gain.
    assign loop_gain_shift = 1'b1;

endmodule

// File: rtl/iir2x_lookahead_chk.sv
// Checker: timing, hold, reset and state-bound properties of the top module.
// Assumes: inputs are in-range signed samples; in_valid is a per-clock strobe.
module iir2x_lookahead_chk #(
    parameter int DATA_W = 12,
    parameter int SW     = 20,
    parameter int GW     = 6,
    parameter int LAT    = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic                     out_valid,
    input logic signed [DATA_W-1:0] out_early,
    input logic signed [DATA_W-1:0] out_late,
    input logic signed [SW-1:0]     y1_e,
    input logic signed [SW-1:0]     y1_o
);
    localparam logic signed [SW-1:0] LIM =
        SW'(((longint'(1) << (DATA_W - 1)) + 1) << GW);

    logic [LAT-1:0] vq;

    // Track accepted input strobes over the pipeline depth.
    always_ff @(posedge clk) begin
        if (!rst_n) vq <= '0;
        else        vq <= (vq << 1) | LAT'(in_valid);
    end

    a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == vq[LAT-1]);

    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && $past(rst_n)) |-> ($stable(out_early) && $stable(out_late)));

    a_r6_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (out_early == '0 && out_late == '0 && !out_valid));

    a_r3_state_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (y1_e <= LIM) && (y1_e >= -LIM) && (y1_o <= LIM) && (y1_o >= -LIM));

endmodule

bind iir2x_lookahead iir2x_lookahead_chk #(
    .DATA_W(DATA_W), .SW(SW), .GW(GUARD_W), .LAT(NUM_STAGES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .out_valid(out_valid),
    .out_early(out_early),
    .out_late (out_late),
    .y1_e     (st_e[1]),
    .y1_o     (st_o[1])
);

// File: tb/iir2x_lookahead_tb.sv
// Bench: drives pairs at the falling edge, compares every output pair with a
// serial real-valued cascade model, and checks latency, hold and reset.
module iir2x_lookahead_tb_top;
    localparam int DW  = 12;
    localparam int GW  = 6;
    localparam int CF  = 8;
    localparam int AQ  = 64;
    localparam int NST = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [DW-1:0] in_early = '0;
    logic signed [DW-1:0] in_late = '0;
    logic out_valid;
    logic signed [DW-1:0] out_early;
    logic signed [DW-1:0] out_late;
    logic loop_gain_shift;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    string cur_tag = "R2";

    real ym [NST];
    real av;
    real q_e [$];
    real q_o [$];
    logic v1 = 1'b0, v2 = 1'b0, rst_s = 1'b0;
    int pe = 0, po = 0;
    logic [15:0] lf = 16'hACE1;

    always #5 clk = ~clk;

    iir2x_lookahead #(
        .DATA_W(DW), .GUARD_W(GW), .COEF_FRAC(CF), .ALPHA_Q(AQ), .NUM_STAGES(NST)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_early(in_early), .in_late(in_late),
        .out_valid(out_valid), .out_early(out_early), .out_late(out_late),
        .loop_gain_shift(loop_gain_shift)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input real act, input real exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0.3f expected %0.3f", tag, what, act, exp);
        end
    endtask

    function automatic real model_step(input int x);
        real v;
        v = real'(x);
        for (int s = 0; s < NST; s++) begin
            ym[s] = (1.0 - av) * ym[s] + av * v;
            v = ym[s];
        end
        return v;
    endfunction

    task automatic model_clear();
        for (int s = 0; s < NST; s++) ym[s] = 0.0;
    endtask

    task automatic send(input int x0, input int x1);
        @(negedge clk);
        in_valid = 1'b1;
        in_early = DW'(x0);
        in_late  = DW'(x1);
        q_e.push_back(model_step(x0));
        q_o.push_back(model_step(x1));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Sample reset and valid as the design sees them at the rising edge.
    always @(posedge clk) begin
        rst_s = rst_n;
        if (!rst_n) begin
            v1 = 1'b0;
            v2 = 1'b0;
        end else begin
            v2 = v1;
            v1 = in_valid;
        end
    end

    // Compare outputs half a clock after each rising edge.
    always @(negedge clk) begin
        if (rst_s) begin
            check(out_valid == v2, "R4", "out_valid timing", real'(out_valid), real'(v2));
            if (out_valid) begin
                if (q_e.size() == 0) begin
                    check(1'b0, "R4", "unexpected output pair", 1.0, 0.0);
                end else begin
                    automatic real ee = q_e.pop_front();
                    automatic real eo = q_o.pop_front();
                    automatic real de = real'(out_early) - ee;
                    automatic real d0 = real'(out_late) - eo;
                    check(de <= 1.0 && de >= -1.0, {cur_tag, "/R1"}, "out_early",
                          real'(out_early), ee);
                    check(d0 <= 1.0 && d0 >= -1.0, {cur_tag, "/R1"}, "out_late",
                          real'(out_late), eo);
                end
            end else begin
                check(int'(out_early) == pe && int'(out_late) == po, "R5",
                      "hold while idle", real'(out_early), real'(pe));
            end
        end
        pe = int'(out_early);
        po = int'(out_late);
    end

    task automatic lf_step();
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    endtask

    task automatic drain();
        idle(NST + 3);
        check(q_e.size() == 0, cur_tag, "all pairs returned", real'(q_e.size()), 0.0);
    endtask

    initial begin
        av = real'(AQ) / (2.0 ** CF);
        model_clear();
        repeat (3) @(negedge clk);
        // R6: reset state; R7: gain flag.
        check(out_early == '0 && out_late == '0 && !out_valid, "R6", "outputs in reset",
              real'(out_early), 0.0);
        check(loop_gain_shift == 1'b1, "R7", "loop_gain_shift", real'(loop_gain_shift), 1.0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: impulse on the early lane.
        cur_tag = "R1";
        send(1000, 0);
        for (int i = 0; i < 20; i++) send(0, 0);
        drain();

        // R8: impulse on the late lane reaches the next early output.
        cur_tag = "R8";
        send(0, 1000);
        for (int i = 0; i < 20; i++) send(0, 0);
        drain();

        // R3: full-scale steps in both directions.
        cur_tag = "R3";
        for (int i = 0; i < 60; i++) send(2047, 2047);
        for (int i = 0; i < 60; i++) send(-2048, -2048);
        for (int i = 0; i < 60; i++) send(2047, -2048);
        drain();

        // R2: DC levels swept across the range.
        cur_tag = "R2";
        for (int lvl = -2048; lvl < 2048; lvl += 256) begin
            for (int i = 0; i < 25; i++) send(lvl, lvl);
        end
        // R1: alternating signs and a ramp make lane order visible.
        cur_tag = "R1";
        for (int i = 0; i < 40; i++) send(1500, -1500);
        for (int i = -1000; i < 1000; i += 50) send(i, i + 25);
        drain();

        // R5: pseudo-random pairs with random idle gaps.
        cur_tag = "R5";
        for (int i = 0; i < 2000; i++) begin
            automatic int a0, a1;
            lf_step(); a0 = int'($signed(lf[11:0]));
            lf_step(); a1 = int'($signed(lf[11:0]));
            send(a0, a1);
            if (lf[3:0] == 4'd0) idle(1 + int'(lf[5:4]));
        end
        drain();

        // R6: reset mid-stream with a non-zero held late sample.
        cur_tag = "R6";
        for (int i = 0; i < 8; i++) send(700, -1800);
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        q_e.delete();
        q_o.delete();
        model_clear();
        check(out_early == '0 && out_late == '0 && !out_valid, "R6", "outputs after reset",
              real'(out_early), 0.0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 5; i++) send(0, 0);
        send(0, 400);
        for (int i = 0; i < 10; i++) send(0, 0);
        drain();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule